// File: doc/BRIEF.md
# Serial Port Front End with Memory Transfer Channels

This block sits between a byte-wide serial path and system memory. Software reaches it through a small word-addressed register file. For each direction it offers a simple transfer channel, so the processor does not have to move every character itself. On the receive side, software loads a memory address and a byte count. Each byte that then arrives on the receive stream is stored at that address. The address moves up by one and the count moves down by one. After a group of bytes has been stored, or once the count is used up, an interrupt line goes high. Further bytes are refused until software clears it.

On the transmit side, a single byte can be sent by writing it to the transmit holding register. For a block of bytes, software first writes a start address and then writes a length to the transmit count register. That second write starts the job at once. The block reads the bytes one at a time from consecutive memory addresses and presents each one on the transmit stream. A busy line stays high until the last byte has been taken.

Both serial streams use valid/ready handshakes. On the transmit stream, once `tx_valid` is high the byte in `tx_data` stays fixed until `tx_ready` is seen high at a clock edge; the sink may hold `tx_ready` low for as long as it likes. On the receive stream, the block drives `rx_ready` low when it cannot store a byte: when the count is zero or an interrupt is pending. A sender must hold `rx_valid` and `rx_data` until the handshake completes. Memory is reached over a single byte port. A write takes effect at the clock edge. Read data comes back one cycle after the request. Only one access happens per cycle, and a receive store wins over a transmit fetch. Line timing, framing and parity belong to a neighbouring block.

Top module: `uart_dma_port`

## Requirements
- R1: The register index is `reg_addr[11:2]` in full (ten bits). Indices 0x5, 0xC, 0xD, 0xE and 0xF are decoded. Index 0x6 reads as zero. Any other index, including 0x1D, which shares its low four bits with 0xD, reads as zero, and writes to it change nothing.
- R2: A write to index 0x7 while no transfer is busy and `tx_valid` is low places `reg_wdata[7:0]` on `tx_data` with `tx_valid` high after that edge. A write to index 0x7 at any other time is dropped.
- R3: Writing an address to index 0xE and then a nonzero N to index 0xF sends N bytes on the transmit stream. They are read from that address upward, in order, and no extra byte follows. Any write to index 0xF while no transfer is busy leaves index 0xE reading zero.
- R4: If index 0xE holds zero, or the value written to index 0xF is zero, then no transfer starts: `tx_busy` stays low and nothing is sent.
- R5: While the receive count (index 0xD) is nonzero and no interrupt is pending, `rx_ready` is high. Each accepted byte is written to memory at the receive address (index 0xC). The address then increments and the count decrements. With a count of zero, `rx_ready` is low.
- R6: `rx_irq` rises after the RX_BATCH-th byte of a group (default 4) or after the byte that brings the count to zero, whichever comes first. It holds, with `rx_ready` low, until `rx_irq_clr` is pulsed.
- R7: The status register at index 0x5 always reads bits 9 and 1 as 1. Bits 3 and 0 read as 1 only while the receive count is nonzero. All other bits read 0.
- R8: Reading index 0xD returns the remaining receive count. Reading index 0xF always returns 0.
- R9: While `tx_valid` is high and `tx_ready` is low, `tx_valid` and `tx_data` hold. `tx_busy` is high from the start of a transfer until the edge at which its last byte is accepted.
- R10: When a receive store and a transmit fetch fall in the same cycle, the store takes the memory port. Both transfers still deliver every byte correctly.
- R11: After reset both counts and addresses are zero, and `rx_ready`, `tx_valid`, `tx_busy`, `rx_irq` and `mem_en` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 12 | Register byte address; bits 11:2 select the register |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr`, combinational |
| rx_valid | input | 1 | Receive byte offered |
| rx_ready | output | 1 | Receive byte can be taken |
| rx_data | input | 8 | Receive byte |
| tx_valid | output | 1 | Transmit byte offered |
| tx_ready | input | 1 | Transmit sink takes the byte |
| tx_data | output | 8 | Transmit byte |
| tx_busy | output | 1 | Memory-to-serial transfer in progress |
| rx_irq | output | 1 | Receive interrupt pending |
| rx_irq_clr | input | 1 | One-cycle pulse that clears the receive interrupt |
| mem_en | output | 1 | Memory access request |
| mem_we | output | 1 | Memory access is a write |
| mem_addr | output | ADDR_W (32) | Memory byte address |
| mem_wdata | output | 8 | Memory write byte |
| mem_rdata | input | 8 | Memory read byte, one cycle after a read request |

## Verification
Some behaviour is checked by assertions on every cycle. These cover the transmit stream holding its byte under back-pressure, and `tx_busy` dropping only on an accepted byte. They also cover the receive address and count each stepping by exactly one per accepted byte. Finally, they check that a pending interrupt holds until it is cleared, and that it is always raised by the byte that drains the count. Other behaviour only the bench scenarios can show: the order and content of bytes fetched from memory, and that a dropped holding-register write leaves no trace. The same goes for register aliasing on the upper index bits, the batch boundary at which the interrupt rises, and a receive transfer and a transmit transfer sharing the memory port without corrupting either.

// File: rtl/uart_dma_pkg.sv
package uart_dma_pkg;
  localparam int unsigned REG_IDX_W = 10;

  localparam logic [REG_IDX_W-1:0] IDX_STAT  = 10'h005;
  localparam logic [REG_IDX_W-1:0] IDX_RHOLD = 10'h006;
  localparam logic [REG_IDX_W-1:0] IDX_THOLD = 10'h007;
  localparam logic [REG_IDX_W-1:0] IDX_RPTR  = 10'h00C;
  localparam logic [REG_IDX_W-1:0] IDX_RCNT  = 10'h00D;
  localparam logic [REG_IDX_W-1:0] IDX_TPTR  = 10'h00E;
  localparam logic [REG_IDX_W-1:0] IDX_TCNT  = 10'h00F;

  localparam int unsigned ST_TX_EMPTY = 9;
  localparam int unsigned ST_RX_END   = 3;
  localparam int unsigned ST_TX_RDY   = 1;
  localparam int unsigned ST_RX_RDY   = 0;
endpackage

// File: rtl/udma_rx_chan.sv
module udma_rx_chan #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned BATCH  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ptr_wr,
  input  logic [ADDR_W-1:0] ptr_wval,
  input  logic              cnt_wr,
  input  logic [CNT_W-1:0]  cnt_wval,
  input  logic              rx_valid,
  input  logic [7:0]        rx_data,
  output logic              rx_ready,
  input  logic              irq_clr,
  output logic              mem_wr_req,
  output logic [ADDR_W-1:0] mem_wr_addr,
  output logic [7:0]        mem_wr_data,
  output logic [ADDR_W-1:0] ptr_q,
  output logic [CNT_W-1:0]  cnt_q,
  output logic              irq_q
);
  localparam int unsigned BCW = (BATCH > 1) ? $clog2(BATCH) : 1;

  logic [BCW-1:0] batch_q;
  logic           fire;
  logic           group_end;

  assign rx_ready    = (cnt_q != '0) && !irq_q;
  assign fire        = rx_valid && rx_ready;
  assign group_end   = (batch_q == BCW'(BATCH - 1)) || (cnt_q == CNT_W'(1));
  assign mem_wr_req  = fire;
  assign mem_wr_addr = ptr_q;
  assign mem_wr_data = rx_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q   <= '0;
      cnt_q   <= '0;
      batch_q <= '0;
      irq_q   <= 1'b0;
    end else begin
      if (ptr_wr)    ptr_q <= ptr_wval;
      else if (fire) ptr_q <= ptr_q + 1'b1;

      if (cnt_wr)    cnt_q <= cnt_wval;
      else if (fire) cnt_q <= cnt_q - 1'b1;

      if (cnt_wr)    batch_q <= '0;
      else if (fire) batch_q <= group_end ? '0 : batch_q + 1'b1;

      if (fire && group_end) irq_q <= 1'b1;
      else if (irq_clr)      irq_q <= 1'b0;
    end
  end

  // R5: one accepted byte moves the count and the address by exactly one
  a_r5_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    fire && !cnt_wr |=> cnt_q == $past(cnt_q) - 1'b1);
  a_r5_ptr_step: assert property (@(posedge clk) disable iff (!rst_n)
    fire && !ptr_wr |=> ptr_q == $past(ptr_q) + 1'b1);
  // R6: a pending interrupt only goes away through the clear pulse
  a_r6_irq_holds: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q && !irq_clr |=> irq_q);
  // R6: the byte that drains the count always raises the interrupt
  a_r6_irq_on_drain: assert property (@(posedge clk) disable iff (!rst_n)
    fire && cnt_q == CNT_W'(1) |=> irq_q);
endmodule

// File: rtl/udma_tx_chan.sv
module udma_tx_chan #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hold_wr,
  input  logic [7:0]        hold_byte,
  input  logic              ptr_wr,
  input  logic [ADDR_W-1:0] ptr_wval,
  input  logic              cnt_wr,
  input  logic [CNT_W-1:0]  cnt_wval,
  output logic              mem_rd_req,
  output logic [ADDR_W-1:0] mem_rd_addr,
  input  logic              mem_rd_gnt,
  input  logic [7:0]        mem_rdata,
  output logic              tx_valid,
  output logic [7:0]        tx_data,
  input  logic              tx_ready,
  output logic              busy,
  output logic [ADDR_W-1:0] ptr_q
);
  logic [ADDR_W-1:0] fetch_addr_q;
  logic [CNT_W-1:0]  remain_q;
  logic              busy_q;
  logic              inflight_q;
  logic              out_valid_q;
  logic [7:0]        out_data_q;
  logic              start;
  logic              issue;
  logic              accept;

  assign start       = cnt_wr && !busy_q && (ptr_q != '0) && (cnt_wval != '0);
  assign mem_rd_req  = busy_q && (remain_q != '0) && !inflight_q && !out_valid_q;
  assign mem_rd_addr = fetch_addr_q;
  assign issue       = mem_rd_req && mem_rd_gnt;
  assign accept      = out_valid_q && tx_ready;
  assign tx_valid    = out_valid_q;
  assign tx_data     = out_data_q;
  assign busy        = busy_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q        <= '0;
      fetch_addr_q <= '0;
      remain_q     <= '0;
      busy_q       <= 1'b0;
      inflight_q   <= 1'b0;
      out_valid_q  <= 1'b0;
      out_data_q   <= '0;
    end else begin
      if (cnt_wr && !busy_q) ptr_q <= '0;
      else if (ptr_wr)       ptr_q <= ptr_wval;

      if (start) begin
        fetch_addr_q <= ptr_q;
        remain_q     <= cnt_wval;
      end else if (issue) begin
        fetch_addr_q <= fetch_addr_q + 1'b1;
        remain_q     <= remain_q - 1'b1;
      end

      inflight_q <= issue;

      if (start) busy_q <= 1'b1;
      else if (accept && busy_q && remain_q == '0 && !inflight_q) busy_q <= 1'b0;

      if (inflight_q) begin
        out_valid_q <= 1'b1;
        out_data_q  <= mem_rdata;
      end else if (accept) begin
        out_valid_q <= 1'b0;
      end else if (hold_wr && !busy_q && !out_valid_q) begin
        out_valid_q <= 1'b1;
        out_data_q  <= hold_byte;
      end
    end
  end

  // R9: an offered byte stays put until the sink takes it
  a_r9_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_ready |=> tx_valid && $stable(tx_data));
  // R9: busy only ends on an accepted byte
  a_r9_busy_ends_on_accept: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_q) |-> $past(accept));
  // R4: a count write with no address never starts a transfer
  a_r4_zero_ptr_idle: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_wr && !busy_q && ptr_q == '0 |=> !busy_q);
endmodule

// File: rtl/uart_dma_port.sv
module uart_dma_port #(
  parameter int unsigned ADDR_W   = 32,
  parameter int unsigned CNT_W    = 16,
  parameter int unsigned RX_BATCH = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [11:0]       reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              rx_valid,
  output logic              rx_ready,
  input  logic [7:0]        rx_data,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic [7:0]        tx_data,
  output logic              tx_busy,
  output logic              rx_irq,
  input  logic              rx_irq_clr,
  output logic              mem_en,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [7:0]        mem_wdata,
  input  logic [7:0]        mem_rdata
);
  import uart_dma_pkg::*;

  logic [REG_IDX_W-1:0] reg_idx;
  logic                 wr_rptr, wr_rcnt, wr_tptr, wr_tcnt, wr_thold;
  logic [ADDR_W-1:0]    rx_ptr, tx_ptr, rx_mem_addr, tx_mem_addr;
  logic [CNT_W-1:0]     rx_cnt;
  logic                 rx_mem_req, tx_mem_req;
  logic [7:0]           rx_mem_data;
  logic                 unused_reg_bits;

  assign reg_idx  = reg_addr[11:2];
  assign wr_rptr  = reg_wr && (reg_idx == IDX_RPTR);
  assign wr_rcnt  = reg_wr && (reg_idx == IDX_RCNT);
  assign wr_tptr  = reg_wr && (reg_idx == IDX_TPTR);
  assign wr_tcnt  = reg_wr && (reg_idx == IDX_TCNT);
  assign wr_thold = reg_wr && (reg_idx == IDX_THOLD);
  assign unused_reg_bits = ^{reg_wdata, reg_addr[1:0]};

  udma_rx_chan #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .BATCH(RX_BATCH)) u_rx (
    .clk        (clk),
    .rst_n      (rst_n),
    .ptr_wr     (wr_rptr),
    .ptr_wval   (reg_wdata[ADDR_W-1:0]),
    .cnt_wr     (wr_rcnt),
    .cnt_wval   (reg_wdata[CNT_W-1:0]),
    .rx_valid   (rx_valid),
    .rx_data    (rx_data),
    .rx_ready   (rx_ready),
    .irq_clr    (rx_irq_clr),
    .mem_wr_req (rx_mem_req),
    .mem_wr_addr(rx_mem_addr),
    .mem_wr_data(rx_mem_data),
    .ptr_q      (rx_ptr),
    .cnt_q      (rx_cnt),
    .irq_q      (rx_irq)
  );

  udma_tx_chan #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_tx (
    .clk        (clk),
    .rst_n      (rst_n),
    .hold_wr    (wr_thold),
    .hold_byte  (reg_wdata[7:0]),
    .ptr_wr     (wr_tptr),
    .ptr_wval   (reg_wdata[ADDR_W-1:0]),
    .cnt_wr     (wr_tcnt),
    .cnt_wval   (reg_wdata[CNT_W-1:0]),
    .mem_rd_req (tx_mem_req),
    .mem_rd_addr(tx_mem_addr),
    .mem_rd_gnt (!rx_mem_req),
    .mem_rdata  (mem_rdata),
    .tx_valid   (tx_valid),
    .tx_data    (tx_data),
    .tx_ready   (tx_ready),
    .busy       (tx_busy),
    .ptr_q      (tx_ptr)
  );

  // Single memory port: receive stores take precedence over transmit fetches
  assign mem_en    = rx_mem_req || tx_mem_req;
  assign mem_we    = rx_mem_req;
  assign mem_addr  = rx_mem_req ? rx_mem_addr : tx_mem_addr;
  assign mem_wdata = rx_mem_data;

  always_comb begin
    reg_rdata = '0;
    case (reg_idx)
      IDX_STAT: begin
        reg_rdata[ST_TX_EMPTY] = 1'b1;
        reg_rdata[ST_TX_RDY]   = 1'b1;
        reg_rdata[ST_RX_END]   = (rx_cnt != '0);
        reg_rdata[ST_RX_RDY]   = (rx_cnt != '0);
      end
      IDX_RHOLD: reg_rdata = '0;
      IDX_RPTR:  reg_rdata = 32'(rx_ptr);
      IDX_RCNT:  reg_rdata = 32'(rx_cnt);
      IDX_TPTR:  reg_rdata = 32'(tx_ptr);
      IDX_TCNT:  reg_rdata = '0;
      default:   reg_rdata = '0;
    endcase
  end

  // R10: a fetch that loses the port is still pending in the next cycle
  a_r10_fetch_retries: assert property (@(posedge clk) disable iff (!rst_n)
    tx_mem_req && rx_mem_req |=> tx_mem_req);
  // R11/R5: no memory write without an accepted receive byte
  a_r5_write_needs_byte: assert property (@(posedge clk) disable iff (!rst_n)
    mem_en && mem_we |-> rx_valid && rx_ready);
endmodule

// File: tb/tb_uart_dma_port.sv
module tb_uart_dma_port;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [11:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        rx_valid = 1'b0;
  logic        rx_ready;
  logic [7:0]  rx_data = '0;
  logic        tx_valid;
  logic        tx_ready = 1'b0;
  logic [7:0]  tx_data;
  logic        tx_busy;
  logic        rx_irq;
  logic        rx_irq_clr = 1'b0;
  logic        mem_en, mem_we;
  logic [31:0] mem_addr;
  logic [7:0]  mem_wdata;
  logic [7:0]  mem_rdata = '0;

  int n_chk = 0;
  int n_err = 0;
  logic [7:0] mem [0:4095];

  always #5 clk = ~clk;

  uart_dma_port dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .rx_valid(rx_valid),
    .rx_ready(rx_ready), .rx_data(rx_data), .tx_valid(tx_valid),
    .tx_ready(tx_ready), .tx_data(tx_data), .tx_busy(tx_busy),
    .rx_irq(rx_irq), .rx_irq_clr(rx_irq_clr), .mem_en(mem_en),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata)
  );

  always @(posedge clk) begin
    if (mem_en && mem_we)  mem[mem_addr[11:0]] <= mem_wdata;
    if (mem_en && !mem_we) mem_rdata <= mem[mem_addr[11:0]];
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic send_rx(input logic [7:0] b);
    rx_data = b; rx_valid = 1'b1;
    while (!rx_ready) @(negedge clk);
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  task automatic take_tx(input string tag, input logic [7:0] exp);
    while (!tx_valid) @(negedge clk);
    chk(tag, {24'h0, tx_data}, {24'h0, exp});
    tx_ready = 1'b1;
    @(negedge clk);
    tx_ready = 1'b0;
  endtask

  task automatic pulse_clr();
    @(negedge clk);
    rx_irq_clr = 1'b1;
    @(negedge clk);
    rx_irq_clr = 1'b0;
  endtask

  localparam int NV = 9;
  localparam logic        T_WE [NV] = '{1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1};
  localparam logic [11:0] T_WA [NV] = '{12'h030, 12'h034, 12'h000, 12'h000, 12'h074,
                                        12'h000, 12'h034, 12'h038, 12'h038};
  localparam logic [31:0] T_WD [NV] = '{32'h100, 32'd5, 32'h0, 32'h0, 32'd9,
                                        32'hFF, 32'd0, 32'h55, 32'h0};
  localparam logic [11:0] T_RA [NV] = '{12'h030, 12'h034, 12'h014, 12'h03C, 12'h034,
                                        12'h000, 12'h014, 12'h038, 12'h038};
  localparam logic [31:0] T_EX [NV] = '{32'h100, 32'd5, 32'h20B, 32'h0, 32'd5,
                                        32'h0, 32'h202, 32'h55, 32'h0};
  string t_tag [NV] = '{"R1 rx address", "R8 rx count", "R7 status active",
                        "R8 tx count reads 0", "R1 alias 0x1D ignored",
                        "R1 unimplemented reads 0", "R7 status idle",
                        "R1 tx address", "R1 tx address clear"};

  initial begin
    repeat (100000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    logic [31:0] v;
    for (int i = 0; i < 4096; i++) mem[i] = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R11: reset state
    chk("R11 rx_ready", {31'h0, rx_ready}, 32'h0);
    chk("R11 tx_valid", {31'h0, tx_valid}, 32'h0);
    chk("R11 tx_busy", {31'h0, tx_busy}, 32'h0);
    chk("R11 rx_irq", {31'h0, rx_irq}, 32'h0);
    chk("R11 mem_en", {31'h0, mem_en}, 32'h0);
    rd(12'h034, v); chk("R11 rx count", v, 32'h0);

    // register vector walk
    for (int k = 0; k < NV; k++) begin
      if (T_WE[k]) wr(T_WA[k], T_WD[k]);
      rd(T_RA[k], v);
      chk(t_tag[k], v, T_EX[k]);
    end

    // R2 / R9: holding register, back-pressure, dropped second write
    wr(12'h01C, 32'h1A5);
    chk("R2 hold valid", {31'h0, tx_valid}, 32'h1);
    chk("R2 hold byte", {24'h0, tx_data}, 32'hA5);
    wr(12'h01C, 32'h33);
    repeat (2) @(negedge clk);
    chk("R9 held under back-pressure", {24'h0, tx_data}, 32'hA5);
    take_tx("R2 hold taken", 8'hA5);
    repeat (3) @(negedge clk);
    chk("R2 second write dropped", {31'h0, tx_valid}, 32'h0);

    // R3 / R9: memory-to-serial transfer
    for (int i = 0; i < 5; i++) mem[12'h200 + i] = 8'h30 + 8'(i * 7);
    wr(12'h038, 32'h200);
    wr(12'h03C, 32'd5);
    chk("R9 busy after start", {31'h0, tx_busy}, 32'h1);
    rd(12'h038, v); chk("R3 address cleared", v, 32'h0);
    rd(12'h03C, v); chk("R8 tx count reads 0", v, 32'h0);
    for (int i = 0; i < 5; i++) take_tx("R3 fetched byte", 8'h30 + 8'(i * 7));
    chk("R9 busy ends on last byte", {31'h0, tx_busy}, 32'h0);
    repeat (10) @(negedge clk);
    chk("R3 no extra byte", {31'h0, tx_valid}, 32'h0);

    // R4: zero address or zero count
    wr(12'h03C, 32'd3);
    repeat (5) @(negedge clk);
    chk("R4 zero address busy", {31'h0, tx_busy}, 32'h0);
    chk("R4 zero address nothing sent", {31'h0, tx_valid}, 32'h0);
    wr(12'h038, 32'h300);
    wr(12'h03C, 32'd0);
    repeat (5) @(negedge clk);
    chk("R4 zero count busy", {31'h0, tx_busy}, 32'h0);
    chk("R4 zero count nothing sent", {31'h0, tx_valid}, 32'h0);
    rd(12'h038, v); chk("R3 count write clears address", v, 32'h0);

    // R5 / R6: serial-to-memory transfer with batching
    wr(12'h030, 32'h400);
    wr(12'h034, 32'd6);
    chk("R5 ready with count", {31'h0, rx_ready}, 32'h1);
    for (int i = 0; i < 4; i++) send_rx(8'hC0 + 8'(i));
    chk("R6 irq after batch", {31'h0, rx_irq}, 32'h1);
    chk("R6 ready low while pending", {31'h0, rx_ready}, 32'h0);
    rd(12'h034, v); chk("R8 remaining count", v, 32'd2);
    rx_data = 8'hEE; rx_valid = 1'b1;
    repeat (3) @(negedge clk);
    rx_valid = 1'b0;
    rd(12'h034, v); chk("R6 held off while pending", v, 32'd2);
    pulse_clr();
    chk("R6 irq cleared", {31'h0, rx_irq}, 32'h0);
    send_rx(8'hC4);
    send_rx(8'hC5);
    chk("R6 irq on drain", {31'h0, rx_irq}, 32'h1);
    pulse_clr();
    chk("R5 ready low at zero count", {31'h0, rx_ready}, 32'h0);
    rd(12'h014, v); chk("R7 status drained", v, 32'h202);
    rd(12'h030, v); chk("R5 address advanced", v, 32'h406);
    for (int i = 0; i < 6; i++)
      chk("R5 stored byte", {24'h0, mem[12'h400 + i]}, {24'h0, 8'hC0 + 8'(i)});

    // R10: both channels share the memory port
    for (int i = 0; i < 3; i++) mem[12'h500 + i] = 8'h80 + 8'(i);
    wr(12'h030, 32'h600);
    wr(12'h034, 32'd3);
    wr(12'h038, 32'h500);
    wr(12'h03C, 32'd3);
    fork
      begin
        send_rx(8'h11);
        send_rx(8'h22);
        send_rx(8'h33);
      end
      begin
        for (int i = 0; i < 3; i++) take_tx("R10 fetched byte", 8'h80 + 8'(i));
      end
    join
    repeat (2) @(negedge clk);
    chk("R10 stored 0", {24'h0, mem[12'h600]}, 32'h11);
    chk("R10 stored 1", {24'h0, mem[12'h601]}, 32'h22);
    chk("R10 stored 2", {24'h0, mem[12'h602]}, 32'h33);
    chk("R10 tx done", {31'h0, tx_busy}, 32'h0);

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule